// File: doc/BRIEF.md
# Host/Controller Command and Completion Ring Pair

This block holds two circular queues of fixed-size entries that connect a host and a storage controller. In the command ring the host produces: it writes an opaque command entry, such as a SCSI command descriptor block and its list of host-memory DMA segments, together with its tail advance. The controller consumes it. In the completion ring the controller produces: it pushes a status code and a tag that names the finished command, and the host consumes it. Both queues are allocated statically. Their depth is a power-of-two parameter, and their indices wrap modulo that depth.

Each producer owns its tail and each consumer owns its head. The two sides sit at opposite ends of a link, so each side sees the other side's index only as a mirrored copy. That copy arrives over a write path with a fixed latency of `LINK_LAT` cycles. A producer judges "full" against its stale copy of the head, and a consumer judges "empty" against its stale copy of the tail. A stale copy can only make a ring look fuller or emptier than it is. An index moves onto the link only after the entry it covers is in storage. The mirrored copies are brought out as ports so that the exchange can be seen.

Top module: `hcr_rings`

## Requirements
- R1: After reset both rings are empty: the empty flags are 1, the full flags are 0, and all four mirrored indices are 0.
- R2: An accepted push at clock edge k makes the consumer's empty flag fall exactly at edge k+LINK_LAT, and not earlier.
- R3: A ring holds at most DEPTH-1 entries. The producer's full flag is 1 when (tail+1) mod DEPTH equals its mirrored head. A push while full is ignored and never overwrites an unread entry.
- R4: A pop while the consumer's empty flag is 1 is ignored. The head and its mirror at the producer do not move.
- R5: Entries leave a ring in the order they entered, with their contents unchanged, across index wraparound.
- R6: An accepted pop at edge m makes the slot visible to the producer at edge m+LINK_LAT: the mirrored head advances there, and a full flag clears there.
- R7: The mirrored copies never run ahead. The occupancy that the consumer sees is never larger than the true occupancy, and the occupancy that the producer sees is never smaller.
- R8: The two rings are independent. Traffic on the completion ring does not change the command ring's flags or indices, and the reverse holds too.
- R9: A completion entry carries an 8-bit status and an 8-bit command tag. Both come out at the host unchanged, in the same fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cmd_push | input | 1 | Host writes one command entry |
| host_cmd_entry | input | CMD_W | Command entry contents |
| host_cmd_full | output | 1 | Command ring looks full to the host |
| host_seen_ctrl_head | output | clog2(DEPTH) | Host's mirror of the controller's command head |
| ctrl_cmd_pop | input | 1 | Controller consumes the oldest command |
| ctrl_cmd_entry | output | CMD_W | Oldest command entry |
| ctrl_cmd_empty | output | 1 | Command ring looks empty to the controller |
| ctrl_seen_host_tail | output | clog2(DEPTH) | Controller's mirror of the host's command tail |
| ctrl_cpl_push | input | 1 | Controller pushes one completion |
| ctrl_cpl_status | input | 8 | Completion status code |
| ctrl_cpl_tag | input | 8 | Tag of the completed command |
| ctrl_cpl_full | output | 1 | Completion ring looks full to the controller |
| ctrl_seen_host_head | output | clog2(DEPTH) | Controller's mirror of the host's completion head |
| host_cpl_pop | input | 1 | Host consumes the oldest completion |
| host_cpl_status | output | 8 | Status of the oldest completion |
| host_cpl_tag | output | 8 | Tag of the oldest completion |
| host_cpl_empty | output | 1 | Completion ring looks empty to the host |
| host_seen_ctrl_tail | output | clog2(DEPTH) | Host's mirror of the controller's completion tail |

## Verification
The assertions check four rules on every cycle: no accepted push lands on an unread slot, no accepted pop passes the true tail, each accepted push advances the tail by exactly one, and both mirrored views of occupancy err only toward the safe side. The directed scenarios cover what needs a known history. They measure the exact edge at which empty and full change after a push or a pop. They check data order across wraparound, that a push into a full ring is lost with no trace, that a pop from an empty ring leaves the indices alone, and that traffic on one ring does not disturb the other.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int STATUS_W = 8;
  localparam int TAG_W    = 8;

  typedef struct packed {
    logic [STATUS_W-1:0] status;
    logic [TAG_W-1:0]    tag;
  } cpl_entry_t;

  localparam int CPL_W = $bits(cpl_entry_t);
endpackage

// File: rtl/hcr_rst_sync.sv
module hcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/hcr_link_delay.sv
module hcr_link_delay #(
  parameter int W   = 3,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign dout = stage_q[LAT-1];
endmodule

// File: rtl/hcr_ring.sv
module hcr_ring #(
  parameter int W        = 32,
  parameter int DEPTH    = 8,
  parameter int LINK_LAT = 3,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prod_push,
  input  logic [W-1:0]  prod_data,
  output logic          prod_full,
  output logic [AW-1:0] prod_head_seen,
  input  logic          cons_pop,
  output logic [W-1:0]  cons_data,
  output logic          cons_empty,
  output logic [AW-1:0] cons_tail_seen
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] tail_q, tail_d, head_q, head_d;
  logic          push_ok, pop_ok;

  // Each index crosses the link only after it has been registered. The entry
  // it covers was written on the same edge, so it is in storage first.
  hcr_link_delay #(.W(AW), .LAT(LINK_LAT)) u_tail_link (
    .clk(clk), .rst_n(rst_n), .din(tail_q), .dout(cons_tail_seen));
  hcr_link_delay #(.W(AW), .LAT(LINK_LAT)) u_head_link (
    .clk(clk), .rst_n(rst_n), .din(head_q), .dout(prod_head_seen));

  assign prod_full  = (tail_q + AW'(1)) == prod_head_seen;
  assign cons_empty = head_q == cons_tail_seen;
  assign push_ok    = prod_push && !prod_full;
  assign pop_ok     = cons_pop && !cons_empty;
  assign cons_data  = mem[head_q];

  always_comb begin
    tail_d = tail_q;
    head_d = head_q;
    if (push_ok) tail_d = tail_q + AW'(1);
    if (pop_ok)  head_d = head_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
    end else begin
      tail_q <= tail_d;
      head_q <= head_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[tail_q] <= prod_data;
  end

  // R3: a push is accepted only while the slot after the tail is not the true head
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> ((tail_q + AW'(1)) != head_q));
  // R4: a pop is accepted only while unread data exists
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> (head_q != tail_q));
  // R2: each accepted push advances the tail by exactly one
  p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (tail_q == $past(tail_q) + AW'(1)));
  // R7: the consumer never sees more entries than exist
  p_cons_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(cons_tail_seen - head_q) <= AW'(tail_q - head_q));
  // R7: the producer never sees fewer entries than exist
  p_prod_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(tail_q - prod_head_seen) >= AW'(tail_q - head_q));
endmodule

// File: rtl/hcr_rings.sv
module hcr_rings
  import hcr_pkg::*;
#(
  parameter int CMD_W    = 64,
  parameter int DEPTH    = 8,
  parameter int LINK_LAT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_cmd_push,
  input  logic [CMD_W-1:0]         host_cmd_entry,
  output logic                     host_cmd_full,
  output logic [$clog2(DEPTH)-1:0] host_seen_ctrl_head,
  input  logic                     ctrl_cmd_pop,
  output logic [CMD_W-1:0]         ctrl_cmd_entry,
  output logic                     ctrl_cmd_empty,
  output logic [$clog2(DEPTH)-1:0] ctrl_seen_host_tail,
  input  logic                     ctrl_cpl_push,
  input  logic [STATUS_W-1:0]      ctrl_cpl_status,
  input  logic [TAG_W-1:0]         ctrl_cpl_tag,
  output logic                     ctrl_cpl_full,
  output logic [$clog2(DEPTH)-1:0] ctrl_seen_host_head,
  input  logic                     host_cpl_pop,
  output logic [STATUS_W-1:0]      host_cpl_status,
  output logic [TAG_W-1:0]         host_cpl_tag,
  output logic                     host_cpl_empty,
  output logic [$clog2(DEPTH)-1:0] host_seen_ctrl_tail
);
  logic       rst_n_int;
  cpl_entry_t cpl_in, cpl_out;

  hcr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  hcr_ring #(.W(CMD_W), .DEPTH(DEPTH), .LINK_LAT(LINK_LAT)) u_cmd (
    .clk(clk), .rst_n(rst_n_int),
    .prod_push(host_cmd_push), .prod_data(host_cmd_entry),
    .prod_full(host_cmd_full), .prod_head_seen(host_seen_ctrl_head),
    .cons_pop(ctrl_cmd_pop), .cons_data(ctrl_cmd_entry),
    .cons_empty(ctrl_cmd_empty), .cons_tail_seen(ctrl_seen_host_tail));

  assign cpl_in.status   = ctrl_cpl_status;
  assign cpl_in.tag      = ctrl_cpl_tag;
  assign host_cpl_status = cpl_out.status;
  assign host_cpl_tag    = cpl_out.tag;

  hcr_ring #(.W(CPL_W), .DEPTH(DEPTH), .LINK_LAT(LINK_LAT)) u_cpl (
    .clk(clk), .rst_n(rst_n_int),
    .prod_push(ctrl_cpl_push), .prod_data(cpl_in),
    .prod_full(ctrl_cpl_full), .prod_head_seen(ctrl_seen_host_head),
    .cons_pop(host_cpl_pop), .cons_data(cpl_out),
    .cons_empty(host_cpl_empty), .cons_tail_seen(host_seen_ctrl_tail));
endmodule

// File: tb/hcr_rings_test.sv
module hcr_rings_test;
  localparam int CMD_W = 64;
  localparam int DEPTH = 8;
  localparam int LAT   = 3;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic host_cmd_push, ctrl_cmd_pop, ctrl_cpl_push, host_cpl_pop;
  logic [CMD_W-1:0] host_cmd_entry, ctrl_cmd_entry;
  logic host_cmd_full, ctrl_cmd_empty, ctrl_cpl_full, host_cpl_empty;
  logic [AW-1:0] host_seen_ctrl_head, ctrl_seen_host_tail, ctrl_seen_host_head, host_seen_ctrl_tail;
  logic [7:0] ctrl_cpl_status, ctrl_cpl_tag, host_cpl_status, host_cpl_tag;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hcr_rings #(.CMD_W(CMD_W), .DEPTH(DEPTH), .LINK_LAT(LAT)) uut (.*);

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd_push(longint unsigned v);
    @(negedge clk);
    host_cmd_push = 1'b1;
    host_cmd_entry = CMD_W'(v);
    @(negedge clk);
    host_cmd_push = 1'b0;
  endtask

  task automatic cmd_pop(string req, longint unsigned exp);
    @(negedge clk);
    check(req, ctrl_cmd_empty, 0);
    check(req, ctrl_cmd_entry, exp);
    ctrl_cmd_pop = 1'b1;
    @(negedge clk);
    ctrl_cmd_pop = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 cmd empty", ctrl_cmd_empty, 1);
    check("R1 cpl empty", host_cpl_empty, 1);
    check("R1 cmd full", host_cmd_full, 0);
    check("R1 cpl full", ctrl_cpl_full, 0);
    check("R1 mirrors", {host_seen_ctrl_head, ctrl_seen_host_tail,
                         ctrl_seen_host_head, host_seen_ctrl_tail}, 0);
  endtask

  task automatic t_latency();
    cmd_push(64'hA5A5_0000_1111_2222);
    check("R2 empty at edge k", ctrl_cmd_empty, 1);
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      check("R2 empty until k+LAT", ctrl_cmd_empty, (i < LAT) ? 1 : 0);
    end
    check("R2 tail mirror", ctrl_seen_host_tail, 1);
    cmd_pop("R5 single entry", 64'hA5A5_0000_1111_2222);
    idle(LAT);
    check("R5 empty after pop", ctrl_cmd_empty, 1);
  endtask

  task automatic t_fill_wrap();
    for (int i = 0; i < DEPTH - 1; i++) cmd_push(64'h100 + i);
    check("R3 full at DEPTH-1", host_cmd_full, 1);
    cmd_push(64'hDEAD);
    check("R3 still full", host_cmd_full, 1);
    idle(LAT + 1);
    check("R3 tail mirror unmoved", ctrl_seen_host_tail, AW'(1 + DEPTH - 1));
    cmd_pop("R5 first after fill", 64'h100);
    check("R6 full right after pop", host_cmd_full, 1);
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      check("R6 full clears at m+LAT", host_cmd_full, (i < LAT) ? 1 : 0);
    end
    check("R6 head mirror", host_seen_ctrl_head, 2);
    for (int i = 1; i < DEPTH - 1; i++) cmd_pop("R5 order across wrap", 64'h100 + i);
    @(negedge clk);
    check("R3 dropped entry absent", ctrl_cmd_empty, 1);
  endtask

  task automatic t_empty_pop();
    logic [AW-1:0] h0;
    idle(LAT + 1);
    h0 = host_seen_ctrl_head;
    @(negedge clk);
    ctrl_cmd_pop = 1'b1;
    idle(2);
    ctrl_cmd_pop = 1'b0;
    idle(LAT + 1);
    check("R4 head mirror unmoved", host_seen_ctrl_head, h0);
    check("R4 still empty", ctrl_cmd_empty, 1);
    cmd_push(64'h0BAD_F00D);
    idle(LAT);
    cmd_pop("R4 next entry intact", 64'h0BAD_F00D);
  endtask

  task automatic t_completion();
    logic [AW-1:0] ct;
    idle(LAT + 1);
    ct = ctrl_seen_host_tail;
    @(negedge clk);
    ctrl_cpl_push = 1'b1;
    ctrl_cpl_status = 8'h3C;
    ctrl_cpl_tag = 8'hE7;
    @(negedge clk);
    ctrl_cpl_status = 8'h00;
    ctrl_cpl_tag = 8'h11;
    @(negedge clk);
    ctrl_cpl_push = 1'b0;
    idle(LAT);
    check("R8 cmd ring untouched", ctrl_cmd_empty, 1);
    check("R8 cmd tail mirror", ctrl_seen_host_tail, ct);
    check("R8 cpl tail mirror", host_seen_ctrl_tail, 2);
    check("R9 status", host_cpl_status, 8'h3C);
    check("R9 tag", host_cpl_tag, 8'hE7);
    host_cpl_pop = 1'b1;
    @(negedge clk);
    check("R9 second status", host_cpl_status, 8'h00);
    check("R9 second tag", host_cpl_tag, 8'h11);
    @(negedge clk);
    host_cpl_pop = 1'b0;
    check("R5 cpl drained", host_cpl_empty, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_cmd_push = 1'b0; ctrl_cmd_pop = 1'b0;
    ctrl_cpl_push = 1'b0; host_cpl_pop = 1'b0;
    host_cmd_entry = '0; ctrl_cpl_status = '0; ctrl_cpl_tag = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_latency();
    t_fill_wrap();
    t_empty_pop();
    t_completion();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule